// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block picks, for each of the two ALU operands of an in-order five-stage pipeline, where the operand value comes from in the execute stage. It compares the source register numbers of the instruction now in execute with the destination register numbers of the two older instructions still in flight: the one just past the ALU and the one in writeback. When an older instruction will write a source register, its result is bypassed onto the operand. Otherwise the value read from the register file is used.

The selection logic is purely combinational. A small operand multiplexer is included, so the block takes the register-file values and the two in-flight results and returns the final operand values. The writeback candidate is either the loaded memory word or the earlier ALU result, chosen by the writeback source flag. Stall generation and branch-compare bypassing belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses 2'b00 for the register-file value, 2'b10 for the result one stage ahead (ALU-output stage) and 2'b01 for the writeback-stage value. The value 2'b11 never appears. With no hazard, both selects are 2'b00.
- R2: A select is 2'b10 when the ALU-output stage has its write flag set, its destination is nonzero and its destination equals that operand's source register.
- R3: A select is 2'b01 when the writeback stage has its write flag set, its destination is nonzero and equal to the operand's source, and the R2 condition for that operand is false.
- R4: When both stages match the same operand, the ALU-output stage (2'b10) wins, so the newest value is used.
- R5: Register 0 is never forwarded. A source of 0 always gives 2'b00, even when a stage with its write flag set names destination 0.
- R6: A stage whose write flag is low causes no forward, whatever its destination. A low write flag in the ALU-output stage does not block a writeback-stage forward.
- R7: The operand output equals the register-file value for 2'b00, the ALU-output-stage result for 2'b10, and for 2'b01 the memory word when the writeback source flag is 1, else the writeback ALU result.
- R8: Operand A (rs) and operand B (rt) are selected independently. The same register can be a hazard for both at once and then both forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 5 | Source register number of operand A (rs) in execute |
| ex_src_b_idx | input | 5 | Source register number of operand B (rt) in execute |
| rf_a_data | input | 32 | Register-file value for operand A |
| rf_b_data | input | 32 | Register-file value for operand B |
| exm_wr_en | input | 1 | ALU-output stage will write a register |
| exm_dst_idx | input | 5 | ALU-output stage destination register |
| exm_alu_res | input | 32 | ALU-output stage result |
| mwb_wr_en | input | 1 | Writeback stage will write a register |
| mwb_dst_idx | input | 5 | Writeback stage destination register |
| mwb_sel_mem | input | 1 | Writeback source: 1 memory word, 0 ALU result |
| mwb_mem_data | input | 32 | Word loaded from data memory |
| mwb_alu_res | input | 32 | Earlier ALU result in writeback |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Final operand A |
| opnd_b | output | 32 | Final operand B |

## Verification
The checks assume that every input carries a defined 0 or 1. They are skipped while any input is unknown, which is why they say nothing about the cycles before the bench first drives the ports. They take no ordering between the two stages for granted, because any combination of write flags and destinations is legal at these ports. The stimulus drives all inputs to known values in a single step at a falling clock edge and samples the outputs a short time later. Destination 0 and register 31 are driven on purpose to reach the field edges.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_W    = 5;
    localparam int DATA_W   = 32;
    localparam int NUM_OPND = 2;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_MEMWB   = 2'b01,
        FWD_EXMEM   = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     wr_en;
        reg_idx_t dst;
    } producer_t;

    function automatic logic writes_reg(input producer_t p);
        return p.wr_en && (p.dst != '0);
    endfunction

    function automatic data_t wb_value(input logic from_mem, input data_t mem_w,
                                       input data_t alu_w);
        return from_mem ? mem_w : alu_w;
    endfunction
endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
(
    input  producer_t prod,
    input  reg_idx_t  src_idx,
    output logic      hit
);
    always_comb begin
        hit = writes_reg(prod) && (prod.dst == src_idx);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  reg_idx_t  src_idx,
    input  producer_t exm,
    input  producer_t mwb,
    output fwd_sel_e  sel
);
    logic exm_hit;
    logic mwb_hit;

    fwd_match u_exm (.prod(exm), .src_idx(src_idx), .hit(exm_hit));
    fwd_match u_mwb (.prod(mwb), .src_idx(src_idx), .hit(mwb_hit));

    always_comb begin
        if (exm_hit)      sel = FWD_EXMEM;
        else if (mwb_hit) sel = FWD_MEMWB;
        else              sel = FWD_REGFILE;
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
(
    input  fwd_sel_e sel,
    input  data_t    rf_val,
    input  data_t    exm_val,
    input  data_t    wb_val,
    output data_t    opnd
);
    always_comb begin
        unique case (sel)
            FWD_EXMEM: opnd = exm_val;
            FWD_MEMWB: opnd = wb_val;
            default:   opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [REG_W-1:0]  ex_src_a_idx,
    input  logic [REG_W-1:0]  ex_src_b_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic              exm_wr_en,
    input  logic [REG_W-1:0]  exm_dst_idx,
    input  logic [DATA_W-1:0] exm_alu_res,
    input  logic              mwb_wr_en,
    input  logic [REG_W-1:0]  mwb_dst_idx,
    input  logic              mwb_sel_mem,
    input  logic [DATA_W-1:0] mwb_mem_data,
    input  logic [DATA_W-1:0] mwb_alu_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    reg_idx_t  src_idx [NUM_OPND];
    data_t     rf_val  [NUM_OPND];
    fwd_sel_e  sel     [NUM_OPND];
    data_t     opnd    [NUM_OPND];
    producer_t exm_p;
    producer_t mwb_p;
    data_t     wb_val;

    assign src_idx[0] = ex_src_a_idx;
    assign src_idx[1] = ex_src_b_idx;
    assign rf_val[0]  = rf_a_data;
    assign rf_val[1]  = rf_b_data;

    assign exm_p  = '{wr_en: exm_wr_en, dst: exm_dst_idx};
    assign mwb_p  = '{wr_en: mwb_wr_en, dst: mwb_dst_idx};
    assign wb_val = wb_value(mwb_sel_mem, mwb_mem_data, mwb_alu_res);

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_select u_sel (
            .src_idx (src_idx[g]),
            .exm     (exm_p),
            .mwb     (mwb_p),
            .sel     (sel[g])
        );
        fwd_operand_mux u_mux (
            .sel     (sel[g]),
            .rf_val  (rf_val[g]),
            .exm_val (exm_alu_res),
            .wb_val  (wb_val),
            .opnd    (opnd[g])
        );
    end

    assign sel_a  = sel[0];
    assign sel_b  = sel[1];
    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
(
    input logic [REG_W-1:0]  ex_src_a_idx,
    input logic [REG_W-1:0]  ex_src_b_idx,
    input logic [DATA_W-1:0] rf_a_data,
    input logic [DATA_W-1:0] rf_b_data,
    input logic              exm_wr_en,
    input logic [REG_W-1:0]  exm_dst_idx,
    input logic [DATA_W-1:0] exm_alu_res,
    input logic              mwb_wr_en,
    input logic [REG_W-1:0]  mwb_dst_idx,
    input logic              mwb_sel_mem,
    input logic [DATA_W-1:0] mwb_mem_data,
    input logic [DATA_W-1:0] mwb_alu_res,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    logic  known;
    data_t wb_exp;

    always_comb begin
        known  = !$isunknown({ex_src_a_idx, ex_src_b_idx, rf_a_data, rf_b_data,
                              exm_wr_en, exm_dst_idx, exm_alu_res, mwb_wr_en,
                              mwb_dst_idx, mwb_sel_mem, mwb_mem_data, mwb_alu_res});
        wb_exp = mwb_sel_mem ? mwb_mem_data : mwb_alu_res;
        if (known) begin
            assert_no_code3_R1: assert (sel_a != 2'b11 && sel_b != 2'b11)
                else $error("select code 11 seen");
            assert_zero_reg_R5: assert ((ex_src_a_idx != '0 || sel_a == 2'b00) &&
                                        (ex_src_b_idx != '0 || sel_b == 2'b00))
                else $error("register 0 forwarded");
            assert_exm_needs_we_R6: assert (exm_wr_en || (sel_a != 2'b10 && sel_b != 2'b10))
                else $error("ALU-stage forward without write flag");
            assert_mwb_source_R3: assert ((sel_a != 2'b01 || (mwb_wr_en && mwb_dst_idx == ex_src_a_idx)) &&
                                          (sel_b != 2'b01 || (mwb_wr_en && mwb_dst_idx == ex_src_b_idx)))
                else $error("writeback forward without matching producer");
            assert_newest_wins_R4: assert (!(exm_wr_en && exm_dst_idx != '0 &&
                                             exm_dst_idx == ex_src_a_idx) || sel_a != 2'b01)
                else $error("older value chosen over newer");
            assert_opnd_value_R7: assert ((sel_a != 2'b10 || opnd_a == exm_alu_res) &&
                                          (sel_a != 2'b01 || opnd_a == wb_exp) &&
                                          (sel_a != 2'b00 || opnd_a == rf_a_data) &&
                                          (sel_b != 2'b10 || opnd_b == exm_alu_res) &&
                                          (sel_b != 2'b01 || opnd_b == wb_exp) &&
                                          (sel_b != 2'b00 || opnd_b == rf_b_data))
                else $error("operand value does not follow select");
        end
    end
endmodule

bind fwd_unit fwd_unit_chk u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  src_a, src_b, edst, mdst;
    logic        ewe, mwe, from_mem;
    logic [31:0] rfa, rfb, ealu, mmem, malu;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fwd_unit u0 (
        .ex_src_a_idx(src_a), .ex_src_b_idx(src_b),
        .rf_a_data(rfa), .rf_b_data(rfb),
        .exm_wr_en(ewe), .exm_dst_idx(edst), .exm_alu_res(ealu),
        .mwb_wr_en(mwe), .mwb_dst_idx(mdst), .mwb_sel_mem(from_mem),
        .mwb_mem_data(mmem), .mwb_alu_res(malu),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // vector: [25:21] src_a, [20:16] src_b, [15] exm we, [14:10] exm dst,
    //         [9] mwb we, [8:4] mwb dst, [3:2] expected sel_a, [1:0] expected sel_b
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {5'd3,  5'd4,  1'b0, 5'd3,  1'b0, 5'd4,  2'b00, 2'b00}, // R6 write flags low
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R2 operand A
        {5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10}, // R2 operand B
        {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd3,  2'b01, 2'b00}, // R3 operand A
        {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01}, // R3 operand B
        {5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10}, // R4 R8 both ops, both stages
        {5'd7,  5'd7,  1'b0, 5'd0,  1'b1, 5'd7,  2'b01, 2'b01}, // R8 same reg both ops
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 5'd4,  2'b10, 2'b01}, // R8 independent
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5 register 0
        {5'd5,  5'd6,  1'b1, 5'd9,  1'b1, 5'd9,  2'b00, 2'b00}, // R1 no match
        {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0,  2'b10, 2'b10}, // R2 top register
        {5'd3,  5'd3,  1'b0, 5'd3,  1'b1, 5'd3,  2'b01, 2'b01}, // R6 idle ALU stage no block
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 5'd3,  2'b10, 2'b00}  // R4 priority on A
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'b10:   return ealu;
            2'b01:   return from_mem ? mmem : malu;
            default: return rf;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        src_a = '0; src_b = '0; edst = '0; mdst = '0;
        ewe = 1'b0; mwe = 1'b0; from_mem = 1'b0;
        rfa = 32'hA0A0_0001; rfb = 32'hB0B0_0002; ealu = 32'h1111_1111;
        mmem = 32'h3333_3333; malu = 32'h2222_2222;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // R1 idle state: no hazard, register-file values pass through
        check("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
        check("R1 idle sel_b", {30'd0, sel_b}, 32'd0);
        check("R7 idle opnd_a", opnd_a, rfa);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {src_a, src_b, ewe, edst, mwe, mdst} = VEC[i][25:4];
            from_mem = i[0];
            #2;
            check($sformatf("vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
            check($sformatf("vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
            check($sformatf("R7 vec%0d opnd_a", i), opnd_a, pick(VEC[i][3:2], rfa));
            check($sformatf("R7 vec%0d opnd_b", i), opnd_b, pick(VEC[i][1:0], rfb));
        end

        // R7 writeback source flag switches the forwarded value
        @(negedge clk);
        src_a = 5'd9; src_b = 5'd9; ewe = 1'b0; mwe = 1'b1; mdst = 5'd9; from_mem = 1'b1;
        #2;
        check("R7 wb from memory", opnd_a, mmem);
        @(negedge clk);
        from_mem = 1'b0;
        #2;
        check("R7 wb from alu", opnd_b, malu);

        // R5 write flag set, destination 0, source 0 on A only
        @(negedge clk);
        src_a = 5'd0; src_b = 5'd2; ewe = 1'b1; edst = 5'd0; mwe = 1'b1; mdst = 5'd2;
        #2;
        check("R5 src0 sel_a", {30'd0, sel_a}, 32'd0);
        check("R5 src0 opnd_a", opnd_a, rfa);
        check("R3 other op sel_b", {30'd0, sel_b}, 32'd1);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule